// File: doc/BRIEF.md
# Two-Phase Noise Shift Register

This block is the noise source of one synthesizer voice. It holds a 23-bit linear feedback shift register and advances it by one position each time a trigger input, driven from a high bit of the voice's phase accumulator, rises. The advance is not a single clock event. A latch phase first copies every register bit into a staging latch that feeds the next bit position, and a commit phase on the following cycle makes the staged values the new register contents. An 8-bit noise sample is read from fixed taps of the register.

When the noise waveform is selected together with triangle, sawtooth or pulse, the combined output pulls the tapped register bits low on the commit. This corruption takes effect only when both phases of one shift carry a combined selection, and only through a waveform that is selected in both phases. A test input holds the block in the latch phase, as reset also does. The commit runs once after either is released.

Top module: `noise_lfsr_2ph`

## Requirements
- R1: While rst_ni is low the register reads 0x7FFFFF. The first rising clock edge after release commits one shift with no writeback, so the register then reads 0x7FFFFE.
- R2: Let k be the first clock edge that samples trig_i high after a low sample, with no shift or test in progress. The register keeps its value through edge k+1 and shows the shifted value after edge k+2.
- R3: A commit without writeback makes the new register value {old[21:0], old[22] ^ old[17]}, with the feedback bit entering bit 0.
- R4: The register changes only on a commit edge. The latch edge and every idle edge leave it unchanged.
- R5: While test_i is high the register holds. After test_i falls, the register shows the committed shift after the second rising edge. The selection present at the first of those edges serves as the latch-phase selection.
- R6: wave_sel_i bit 3 selects noise, bit 2 pulse, bit 1 sawtooth and bit 0 triangle. Writeback happens only if bit 3 is set in both the latch-phase and commit-phase selections and the two selections share at least one of bits 2 to 0.
- R7: On writeback, each tapped bit of the shifted value is ANDed with the matching bit of the bitwise AND of the input waveforms (tri_i, saw_i, pul_i) selected in both phases. Those inputs are sampled at the commit edge. Untapped bits keep their shifted value.
- R8: noise_o is {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2]} of the current register r, most significant first. The tap for noise_o bit i pairs with waveform bit i in R7.
- R9: A trigger rise sampled while a shift is in progress starts no shift. A waveform selection outside the two phases has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_i | input | 1 | Holds the shift in its latch phase while high |
| trig_i | input | 1 | Accumulator bit whose rise starts a shift |
| wave_sel_i | input | 4 | Waveform select: noise, pulse, sawtooth, triangle (bits 3 to 0) |
| tri_i | input | 8 | Triangle waveform output, used for writeback |
| saw_i | input | 8 | Sawtooth waveform output, used for writeback |
| pul_i | input | 8 | Pulse waveform output, used for writeback |
| noise_o | output | 8 | Noise sample from the register taps |
| lfsr_o | output | 23 | Current register contents |

## Verification
A trigger first sampled high at edge k gives its result after edge k+2. Edge k+1 is the latch edge, so the bench reads the register at the falling edges after k and after k+1, expects no change there, and compares against the model at the falling edge after k+2. A release of test gives its commit after the second following edge. A release of reset gives its commit after the first. The bench also checks at every falling edge in between that the register has not moved. The latch-phase selection is applied for exactly the edge that samples it, and the commit selection and waveform values are applied for the commit edge.

// File: rtl/noise_pkg.sv
package noise_pkg;

    localparam int unsigned NZ_REG_W = 23;
    localparam int unsigned NZ_OUT_W = 8;
    localparam int unsigned NZ_SEL_W = 4;
    localparam int unsigned NZ_FB_HI = 22;
    localparam int unsigned NZ_FB_LO = 17;

    // selection bit positions
    localparam int unsigned SEL_TRI = 0;
    localparam int unsigned SEL_SAW = 1;
    localparam int unsigned SEL_PUL = 2;
    localparam int unsigned SEL_NZ  = 3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LATCH  = 2'd1,
        PH_COMMIT = 2'd2
    } phase_e;

    // register position feeding sample bit idx
    function automatic int tap_pos(input int idx);
        case (idx)
            0: return 2;
            1: return 4;
            2: return 7;
            3: return 11;
            4: return 13;
            5: return 16;
            6: return 20;
            default: return 22;
        endcase
    endfunction

    // sample bit fed by register position pos, or -1
    function automatic int tap_slot(input int pos);
        for (int i = 0; i < int'(NZ_OUT_W); i++) begin
            if (tap_pos(i) == pos) return i;
        end
        return -1;
    endfunction

endpackage

// File: rtl/noise_trig_edge.sv
module noise_trig_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic rise_o
);
    typedef struct packed {
        logic trig;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trig = trig_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = trig_i & ~st_q.trig;
endmodule

// File: rtl/noise_phase_ctrl.sv
module noise_phase_ctrl
    import noise_pkg::*;
#(
    parameter int unsigned SEL_W = NZ_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    input  logic             test_i,
    input  logic [SEL_W-1:0] wave_sel_i,
    output phase_e           phase_o,
    output logic [SEL_W-1:0] sel_p1_o
);
    typedef struct packed {
        phase_e           phase;
        logic [SEL_W-1:0] sel_p1;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (test_i || rise_i) st_d.phase = PH_LATCH;
            end
            PH_LATCH: begin
                st_d.sel_p1 = wave_sel_i;
                st_d.phase  = test_i ? PH_LATCH : PH_COMMIT;
            end
            PH_COMMIT: begin
                // a rise seen here is dropped
                st_d.phase = test_i ? PH_LATCH : PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    // reset parks in commit with a clean phase-1 selection:
    // release commits once, with no writeback
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase  <= PH_COMMIT;
            st_q.sel_p1 <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign sel_p1_o = st_q.sel_p1;
endmodule

// File: rtl/noise_wb_mask.sv
module noise_wb_mask
    import noise_pkg::*;
#(
    parameter int unsigned SEL_W = NZ_SEL_W,
    parameter int unsigned OUT_W = NZ_OUT_W
) (
    input  logic [SEL_W-1:0] sel_p1_i,
    input  logic [SEL_W-1:0] sel_p2_i,
    input  logic [OUT_W-1:0] tri_i,
    input  logic [OUT_W-1:0] saw_i,
    input  logic [OUT_W-1:0] pul_i,
    output logic             wb_en_o,
    output logic [OUT_W-1:0] wb_val_o
);
    logic [SEL_W-1:0] shared;

    always_comb begin
        shared  = sel_p1_i & sel_p2_i;
        wb_en_o = shared[SEL_NZ] &
                  (shared[SEL_TRI] | shared[SEL_SAW] | shared[SEL_PUL]);
        wb_val_o = '1;
        if (shared[SEL_TRI]) wb_val_o = wb_val_o & tri_i;
        if (shared[SEL_SAW]) wb_val_o = wb_val_o & saw_i;
        if (shared[SEL_PUL]) wb_val_o = wb_val_o & pul_i;
    end
endmodule

// File: rtl/noise_lfsr_2ph.sv
module noise_lfsr_2ph
    import noise_pkg::*;
#(
    parameter int unsigned LFSR_W = NZ_REG_W,
    parameter int unsigned FB_HI  = NZ_FB_HI,
    parameter int unsigned FB_LO  = NZ_FB_LO,
    parameter int unsigned OUT_W  = NZ_OUT_W,
    parameter int unsigned SEL_W  = NZ_SEL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              test_i,
    input  logic              trig_i,
    input  logic [SEL_W-1:0]  wave_sel_i,
    input  logic [OUT_W-1:0]  tri_i,
    input  logic [OUT_W-1:0]  saw_i,
    input  logic [OUT_W-1:0]  pul_i,
    output logic [OUT_W-1:0]  noise_o,
    output logic [LFSR_W-1:0] lfsr_o
);
    localparam logic [LFSR_W-1:0] RST_REG   = '1;
    localparam logic [LFSR_W-1:0] RST_LATCH = {{(LFSR_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [LFSR_W-1:0] latch;
    } reg_st_t;

    reg_st_t           st_d, st_q;
    logic              rise;
    phase_e            phase;
    logic [SEL_W-1:0]  sel_p1;
    logic              wb_en;
    logic [OUT_W-1:0]  wb_val;
    logic [OUT_W-1:0]  keep_tap;
    logic [LFSR_W-1:0] keep;
    logic [LFSR_W-1:0] shifted;
    logic [LFSR_W-1:0] latch_w;

    noise_trig_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (trig_i),
        .rise_o (rise)
    );

    noise_phase_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rise_i     (rise),
        .test_i     (test_i),
        .wave_sel_i (wave_sel_i),
        .phase_o    (phase),
        .sel_p1_o   (sel_p1)
    );

    noise_wb_mask #(.SEL_W(SEL_W), .OUT_W(OUT_W)) u_wb (
        .sel_p1_i (sel_p1),
        .sel_p2_i (wave_sel_i),
        .tri_i    (tri_i),
        .saw_i    (saw_i),
        .pul_i    (pul_i),
        .wb_en_o  (wb_en),
        .wb_val_o (wb_val)
    );

    // per-tap keep bits, then spread over the register positions
    for (genvar g = 0; g < OUT_W; g++) begin : g_keep_tap
        assign keep_tap[g] = wb_val[g] | ~wb_en;
        assign noise_o[g]  = st_q.lfsr[tap_pos(g)];
    end

    for (genvar b = 0; b < LFSR_W; b++) begin : g_keep
        localparam int SLOT = tap_slot(b);
        if (SLOT >= 0) begin : g_tap
            assign keep[b] = keep_tap[SLOT];
        end else begin : g_plain
            assign keep[b] = 1'b1;
        end
    end

    always_comb begin
        shifted = {st_q.lfsr[LFSR_W-2:0], st_q.lfsr[FB_HI] ^ st_q.lfsr[FB_LO]};
        st_d    = st_q;
        unique case (phase)
            PH_LATCH:  st_d.latch = shifted;
            PH_COMMIT: st_d.lfsr  = st_q.latch & keep;
            default:   ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.lfsr  <= RST_REG;
            st_q.latch <= RST_LATCH;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_w = st_q.latch;
    assign lfsr_o  = st_q.lfsr;
endmodule

// File: rtl/noise_lfsr_2ph_chk.sv
module noise_lfsr_2ph_chk
    import noise_pkg::*;
#(
    parameter int unsigned LFSR_W = NZ_REG_W,
    parameter int unsigned OUT_W  = NZ_OUT_W
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              test_i,
    input logic              trig_i,
    input phase_e            phase,
    input logic [LFSR_W-1:0] latch,
    input logic [LFSR_W-1:0] lfsr_o,
    input logic [OUT_W-1:0]  noise_o
);
    function automatic logic [LFSR_W-1:0] untapped_mask();
        logic [LFSR_W-1:0] m;
        for (int b = 0; b < int'(LFSR_W); b++) m[b] = (tap_slot(b) < 0);
        return m;
    endfunction

    localparam logic [LFSR_W-1:0] UNTAP = untapped_mask();

    assert_change_on_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lfsr_o) |-> $past(phase == PH_COMMIT));

    assert_start_after_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && !$past(trig_i) && phase == PH_IDLE && !test_i) |=> (phase == PH_LATCH));

    assert_test_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_i && phase != PH_COMMIT) |=> $stable(lfsr_o));

    assert_untapped_from_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == PH_COMMIT) |=> (((lfsr_o ^ $past(latch)) & UNTAP) == '0));

    assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == PH_COMMIT && !test_i) |=> (phase == PH_IDLE));

    assert_sample_tracks_reg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(lfsr_o) |-> $stable(noise_o));
endmodule

bind noise_lfsr_2ph noise_lfsr_2ph_chk #(.LFSR_W(LFSR_W), .OUT_W(OUT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .test_i  (test_i),
    .trig_i  (trig_i),
    .phase   (phase),
    .latch   (latch_w),
    .lfsr_o  (lfsr_o),
    .noise_o (noise_o)
);

// File: tb/sim_noise_lfsr_2ph.sv
module sim_noise_lfsr_2ph;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test = 1'b0;
    logic        trig = 1'b0;
    logic [3:0]  sel = 4'h0;
    logic [7:0]  tw = 8'h00, sw = 8'h00, pw = 8'h00;
    logic [7:0]  noise;
    logic [22:0] lfsr;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [22:0] mdl;

    always #5 clk = ~clk;

    noise_lfsr_2ph u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .test_i     (test),
        .trig_i     (trig),
        .wave_sel_i (sel),
        .tri_i      (tw),
        .saw_i      (sw),
        .pul_i      (pw),
        .noise_o    (noise),
        .lfsr_o     (lfsr)
    );

    function automatic logic [22:0] f_shift(input logic [22:0] r);
        return {r[21:0], r[22] ^ r[17]};
    endfunction

    function automatic logic [7:0] f_noise(input logic [22:0] r);
        return {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2]};
    endfunction

    function automatic bit f_wb(input logic [3:0] s1, input logic [3:0] s2);
        return s1[3] && s2[3] && ((s1[2:0] & s2[2:0]) != 3'b000);
    endfunction

    function automatic logic [22:0] f_commit(input logic [22:0] r, input logic [3:0] s1,
                                             input logic [3:0] s2, input logic [7:0] t,
                                             input logic [7:0] s, input logic [7:0] p);
        logic [22:0] n;
        logic [2:0]  c;
        logic [7:0]  v;
        n = f_shift(r);
        c = s1[2:0] & s2[2:0];
        if (f_wb(s1, s2)) begin
            v = 8'hFF;
            if (c[0]) v = v & t;
            if (c[1]) v = v & s;
            if (c[2]) v = v & p;
            n[22] = n[22] & v[7];
            n[20] = n[20] & v[6];
            n[16] = n[16] & v[5];
            n[13] = n[13] & v[4];
            n[11] = n[11] & v[3];
            n[7]  = n[7]  & v[2];
            n[4]  = n[4]  & v[1];
            n[2]  = n[2]  & v[0];
        end
        return n;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [22:0] exp);
        n_chk++;
        if (lfsr !== exp) begin
            n_fail++;
            $display("FAIL %s: lfsr=%06h expected %06h", req, lfsr, exp);
        end
        n_chk++;
        if (noise !== f_noise(exp)) begin
            n_fail++;
            $display("FAIL R8 (%s): noise=%02h expected %02h", req, noise, f_noise(exp));
        end
    endtask

    task automatic rand_waves();
        tw = 8'($urandom);
        sw = 8'($urandom);
        pw = 8'($urandom);
    endtask

    task automatic do_reset(input int k);
        rst_n = 1'b0;
        trig  = 1'b0;
        test  = 1'b0;
        for (int i = 0; i < k; i++) begin
            tick();
            chk_reg("R1 held reset", 23'h7FFFFF);
        end
        rst_n = 1'b1;
        mdl   = f_shift(23'h7FFFFF);
        tick();
        chk_reg("R1 release commit", mdl);
        tick();
        chk_reg("R1 idle after release", mdl);
    endtask

    // called at a falling edge, trig low, block idle
    task automatic do_shift(input logic [3:0] s1, input logic [3:0] s2, input bit glitch);
        trig = 1'b1;
        tick();
        sel = s1;
        if (glitch) trig = 1'b0;
        chk_reg("R2 no change at rise edge", mdl);
        tick();
        sel = s2;
        rand_waves();
        if (glitch) trig = 1'b1;
        chk_reg("R4 latch edge keeps register", mdl);
        tick();
        mdl = f_commit(mdl, s1, s2, tw, sw, pw);
        chk_reg(f_wb(s1, s2) ? "R6 R7 writeback commit" : "R3 R6 plain commit", mdl);
        if (glitch) begin
            sel = 4'hF;
            tick();
            chk_reg("R9 rise during commit ignored", mdl);
            tick();
            chk_reg("R9 rise during commit ignored", mdl);
        end
        trig = 1'b0;
        sel  = 4'($urandom);
        rand_waves();
        tick();
        chk_reg("R9 idle selection ignored", mdl);
    endtask

    task automatic test_hold(input int k, input logic [3:0] s1, input logic [3:0] s2);
        test = 1'b1;
        sel  = 4'($urandom);
        for (int i = 0; i < k; i++) begin
            tick();
            sel = 4'($urandom);
            chk_reg("R5 held test", mdl);
        end
        test = 1'b0;
        sel  = s1;
        tick();
        chk_reg("R5 first edge after release", mdl);
        sel = s2;
        rand_waves();
        tick();
        mdl = f_commit(mdl, s1, s2, tw, sw, pw);
        chk_reg(f_wb(s1, s2) ? "R5 R6 commit after test" : "R5 commit after test", mdl);
        sel = 4'h0;
        tick();
        chk_reg("R4 idle after test", mdl);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(10 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
    end

    initial begin
        logic [3:0] a;
        logic [3:0] b;
        void'($urandom(32'd20160819));
        tick();
        tick();
        chk_reg("R1 reset value", 23'h7FFFFF);
        do_reset(3);

        // idle selections touch nothing
        sel = 4'hB;
        rand_waves();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_reg("R9 idle combined select", mdl);
        end
        sel = 4'h0;

        // plain shifts to spread the pattern
        for (int i = 0; i < 6; i++) do_shift(4'h8, 4'h8, 1'b0);

        // directed phase pairs
        do_shift(4'h8, 4'hA, 1'b0);   // noise then noise+saw: none
        do_shift(4'hA, 4'h8, 1'b0);   // noise+saw then noise: none
        do_shift(4'h9, 4'hA, 1'b0);   // different partners: none
        do_shift(4'h2, 4'hA, 1'b0);   // no noise in phase 1: none
        do_shift(4'hA, 4'hA, 1'b0);   // same pair: writeback
        do_reset(2);
        do_shift(4'hA, 4'hB, 1'b0);   // shared saw: writeback
        do_reset(1);
        do_shift(4'hF, 4'hC, 1'b0);   // shared pulse: writeback
        do_reset(1);
        do_shift(4'h8, 4'h8, 1'b1);   // re-rise during commit
        test_hold(4, 4'h8, 4'h8);
        test_hold(3, 4'h9, 4'h9);
        do_reset(1);
        test_hold(1, 4'h8, 4'hB);

        // seeded random mix
        for (int it = 0; it < 400; it++) begin
            a = 4'($urandom);
            b = 4'($urandom);
            if (($urandom % 4) != 0) a[3] = 1'b1;
            if (($urandom % 4) != 0) b[3] = 1'b1;
            if ((it % 50) == 49) do_reset(1 + int'($urandom % 3));
            else if ((it % 9) == 4) test_hold(1 + int'($urandom % 5), a, b);
            else do_shift(a, b, (($urandom % 8) == 0));
        end

        summary();
    end

endmodule